// File: doc/BRIEF.md
# Register Window Decoder

This block sits behind a single 4 KiB memory-mapped window and routes each access to one of three sub-windows.

- **Legacy port range.** A 32-byte range of byte-wide legacy display I/O ports, relocated so that its first byte is legacy port 0x3C0.
- **Mode-register file.** An indexed file of 16-bit mode registers. The register index comes from the address.
- **Extension bank.** A small bank of two 32-bit registers. One reports the bank size; the other holds the framebuffer byte-order flag, which this block keeps itself.

A requester raises `req` with address, size, direction and write data, and holds them steady until `ready` pulses. The block drives two simple downstream strobe ports, one per sub-window. Each downstream port returns read data combinationally in the same cycle as its strobe.

A 16-bit access to the legacy range is split into two byte accesses on consecutive cycles. The low byte goes to the addressed port first, then the high byte goes to the port after it. Software can therefore load an index register and its data register with one word write. The extension bank can be switched off by a configuration input, and the revision output reflects that choice.

Top module: `regwin_decoder`

## Requirements
- R1: After reset `ready` is low and the byte-order flag is little-endian (`big_endian` = 0). A reset taken while the flag is big-endian returns it to little-endian.
- R2: A byte access at window offset 0x400+k (k < 0x20) gives exactly one legacy strobe, on port 0x3C0+k. Write data is `wdata[7:0]`, and read data returns in `rdata[7:0]` with upper bits zero.
- R3: A 16-bit or 32-bit write to the legacy range (size code 1 or 2) gives two legacy strobes on consecutive cycles. The first carries `wdata[7:0]` to the addressed port; the second carries `wdata[15:8]` to the addressed port plus one.
- R4: A 16-bit read from the legacy range returns the addressed port in `rdata[7:0]` and the next port in `rdata[15:8]`, with upper bits zero.
- R5: Any access at offset 0x500+k (k < 0x16) gives one mode-register strobe with index k>>1. The strobe carries `wdata[15:0]` regardless of access size, and read data returns in `rdata[15:0]`.
- R6: With the extension bank enabled, a 32-bit read at offset 0x600 returns 8.
- R7: A 32-bit read at 0x604 returns 0x1E1E1E1E when little-endian and 0xBEBEBEBE when big-endian. A 32-bit write of 0xBEBEBEBE there selects big-endian; a write of 0x1E1E1E1E selects little-endian.
- R8: A 32-bit write of any other value to 0x604 leaves the byte-order flag unchanged. A write to 0x600 also leaves the flag unchanged.
- R9: In the extension bank, accesses that are not 32 bits wide, and word accesses at a misaligned offset, read zero and have no effect.
- R10: `revision` is 2 while `qext_en` is 1 and 1 while it is 0. With the bank disabled, its offsets read zero and writes there leave the flag unchanged.
- R11: An access outside all three sub-windows completes, reads zero, and raises no downstream strobe.
- R12: `ready` is a one-cycle pulse. It comes in the 2nd cycle of a request for single-step accesses and in the 3rd cycle for a split legacy access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qext_en | input | 1 | Enables the extension bank |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| addr | input | 12 | Byte offset inside the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | Access complete pulse |
| revision | output | 8 | 2 with extension bank, 1 without |
| big_endian | output | 1 | Framebuffer byte-order flag |
| lp_valid | output | 1 | Legacy port strobe |
| lp_we | output | 1 | Legacy port write |
| lp_port | output | 10 | Legacy port number |
| lp_wdata | output | 8 | Legacy port write byte |
| lp_rdata | input | 8 | Legacy port read byte (same cycle) |
| mr_valid | output | 1 | Mode-register strobe |
| mr_we | output | 1 | Mode-register write |
| mr_index | output | 4 | Mode-register index |
| mr_wdata | output | 16 | Mode-register write data |
| mr_rdata | input | 16 | Mode-register read data (same cycle) |

## Verification
The downstream models return a port-dependent or index-dependent value, so a wrong port, index or byte lane shows up as a different read word.

Legacy reads are tried as single bytes and as half-words at the start and end of the range. This separates correct byte ordering and port increments from swapped or repeated bytes.

Offsets one past each sub-window check the window bounds. Byte-order writes use both magic values, a value one bit away from a magic value, and narrow writes, which separates the two-value acceptance from a plain register load. Toggling the enable and taking a mid-run reset checks revision and the reset value of the flag.

// File: rtl/regwin_pkg.sv
// Shared types and constants for the register window decoder.
// Assumes: size encoding 0/1/2 = byte/half/word.
package regwin_pkg;
    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
    typedef enum logic [1:0] {WIN_NONE, WIN_LEGACY, WIN_MODE, WIN_EXT} win_e;
    typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_RESP} seq_e;
    localparam logic [31:0] ORDER_LITTLE = 32'h1E1E_1E1E;
    localparam logic [31:0] ORDER_BIG    = 32'hBEBE_BEBE;
endpackage

// File: rtl/regwin_addr_dec.sv
// Address decoder: finds which sub-window an offset hits and the offset
// relative to that sub-window's base. Assumes windows do not overlap.
module regwin_addr_dec
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int LEG_BASE  = 'h400,
    parameter int LEG_SPAN  = 'h20,
    parameter int MODE_BASE = 'h500,
    parameter int MODE_SPAN = 'h16,
    parameter int EXT_BASE  = 'h600,
    parameter int EXT_SPAN  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_en,
    output win_e              win,
    output logic [ADDR_W-1:0] off
);
    localparam int NWIN = 3;
    localparam int BASES [NWIN] = '{LEG_BASE, MODE_BASE, EXT_BASE};
    localparam int SPANS [NWIN] = '{LEG_SPAN, MODE_SPAN, EXT_SPAN};

    logic [NWIN-1:0] hit;
    logic [31:0]     a32;
    assign a32 = 32'(addr);

    // one range comparator per sub-window
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign hit[g] = (a32 >= 32'(BASES[g])) && (a32 < 32'(BASES[g] + SPANS[g]));
    end

    // select the window and its relative offset
    always_comb begin
        win = WIN_NONE;
        off = '0;
        if (hit[0]) begin
            win = WIN_LEGACY;
            off = addr - ADDR_W'(LEG_BASE);
        end else if (hit[1]) begin
            win = WIN_MODE;
            off = addr - ADDR_W'(MODE_BASE);
        end else if (hit[2] && ext_en) begin
            win = WIN_EXT;
            off = addr - ADDR_W'(EXT_BASE);
        end
    end
endmodule

// File: rtl/regwin_ext_bank.sv
// Extension register bank: register 0 reports the bank size, register 1
// holds the framebuffer byte-order flag, loaded only by one of two magic
// values. Assumes the caller qualifies wr_en to word-sized, aligned writes.
module regwin_ext_bank
    import regwin_pkg::*;
#(
    parameter int EXT_SPAN = 8,
    localparam int IDX_W   = (EXT_SPAN / 4 > 1) ? $clog2(EXT_SPAN / 4) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             big_endian
);
    logic big_q;

    // byte-order flag: reset little-endian, set or cleared only by magic values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_q <= 1'b0;
        end else if (wr_en && reg_idx == IDX_W'(1)) begin
            if (wdata == ORDER_BIG) begin
                big_q <= 1'b1;
            end else if (wdata == ORDER_LITTLE) begin
                big_q <= 1'b0;
            end
        end
    end

    // read mux over the bank registers
    always_comb begin
        case (reg_idx)
            IDX_W'(0): rdata = 32'(EXT_SPAN);
            IDX_W'(1): rdata = big_q ? ORDER_BIG : ORDER_LITTLE;
            default:   rdata = '0;
        endcase
    end

    assign big_endian = big_q;

    // R7
    order_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_W'(1) && wdata == ORDER_BIG) |=> big_endian);

    // R8
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != ORDER_BIG && wdata != ORDER_LITTLE) |=> $stable(big_endian));
endmodule

// File: rtl/regwin_decoder.sv
// Register window decoder top: decodes the offset, drives the legacy-port
// and mode-register strobe ports, splits wide legacy accesses into two
// ordered byte steps and answers extension-bank accesses.
// Assumes the requester holds req, addr, size, we and wdata stable until
// the ready pulse and drops req in the cycle after it. Downstream read
// data is combinational in the cycle of the strobe.
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PORT_W     = 10,
    parameter int PORT_BASE  = 'h3C0,
    parameter int LEG_BASE   = 'h400,
    parameter int LEG_SPAN   = 'h20,
    parameter int MODE_BASE  = 'h500,
    parameter int MODE_SPAN  = 'h16,
    parameter int EXT_BASE   = 'h600,
    parameter int EXT_SPAN   = 8,
    parameter int REV_PLAIN  = 1,
    parameter int REV_EXT    = 2,
    localparam int MR_IDX_W  = $clog2(MODE_SPAN / 2),
    localparam int LEG_W     = $clog2(LEG_SPAN),
    localparam int EXT_IDX_W = (EXT_SPAN / 4 > 1) ? $clog2(EXT_SPAN / 4) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                qext_en,
    input  logic                req,
    input  logic                we,
    input  logic [1:0]          size,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                ready,
    output logic [7:0]          revision,
    output logic                big_endian,
    output logic                lp_valid,
    output logic                lp_we,
    output logic [PORT_W-1:0]   lp_port,
    output logic [7:0]          lp_wdata,
    input  logic [7:0]          lp_rdata,
    output logic                mr_valid,
    output logic                mr_we,
    output logic [MR_IDX_W-1:0] mr_index,
    output logic [15:0]         mr_wdata,
    input  logic [15:0]         mr_rdata
);
    win_e              win;
    logic [ADDR_W-1:0] off;
    seq_e              state;
    logic [31:0]       rd_q;
    logic [31:0]       ext_rdata;
    logic              ext_ok;
    logic              ext_wr;
    logic              issue;
    logic              in_hi;
    acc_size_e         sz;

    assign sz = acc_size_e'(size);

    regwin_addr_dec #(
        .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
        .MODE_BASE(MODE_BASE), .MODE_SPAN(MODE_SPAN),
        .EXT_BASE(EXT_BASE), .EXT_SPAN(EXT_SPAN)
    ) u_dec (
        .addr(addr), .ext_en(qext_en), .win(win), .off(off)
    );

    regwin_ext_bank #(.EXT_SPAN(EXT_SPAN)) u_ext (
        .clk(clk), .rst_n(rst_n), .wr_en(ext_wr),
        .reg_idx(off[EXT_IDX_W+1:2]), .wdata(wdata),
        .rdata(ext_rdata), .big_endian(big_endian)
    );

    assign issue  = (state == ST_IDLE) && req;
    assign in_hi  = (state == ST_HI);
    assign ext_ok = (sz == SZ_WORD) && (off[1:0] == 2'b00);

    // downstream strobes and data, driven from the current step
    always_comb begin
        lp_valid = 1'b0;
        mr_valid = 1'b0;
        ext_wr   = 1'b0;
        case (win)
            WIN_LEGACY: lp_valid = issue || in_hi;
            WIN_MODE:   mr_valid = issue;
            WIN_EXT:    ext_wr   = issue && we && ext_ok;
            default:    ;
        endcase
        lp_we    = we;
        lp_port  = PORT_W'(PORT_BASE) + PORT_W'(off[LEG_W-1:0]) + PORT_W'(in_hi);
        lp_wdata = in_hi ? wdata[15:8] : wdata[7:0];
        mr_we    = we;
        mr_index = off[MR_IDX_W:1];
        mr_wdata = wdata[15:0];
    end

    // access sequencer: issue step, optional high-byte step, response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rd_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    state <= ST_RESP;
                    case (win)
                        WIN_LEGACY: begin
                            rd_q <= {24'h0, lp_rdata};
                            if (sz != SZ_BYTE) state <= ST_HI;
                        end
                        WIN_MODE: rd_q <= {16'h0, mr_rdata};
                        WIN_EXT:  rd_q <= ext_ok ? ext_rdata : 32'h0;
                        default:  rd_q <= '0;
                    endcase
                end
                ST_HI: begin
                    rd_q[15:8] <= lp_rdata;
                    state      <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready    = (state == ST_RESP);
    assign rdata    = rd_q;
    assign revision = qext_en ? 8'(REV_EXT) : 8'(REV_PLAIN);

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R3
    split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && win == WIN_LEGACY && sz != SZ_BYTE) |=> (lp_valid && !ready));

    // R3
    hi_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hi && lp_valid) |-> (lp_port == PORT_W'($past(lp_port) + 1'b1)));

    // R11
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && win == WIN_NONE) |-> (!lp_valid && !mr_valid) ##1 (rdata == 32'h0));
endmodule

// File: tb/regwin_decoder_tb.sv
module regwin_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qext_en = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;
    logic [7:0]  revision;
    logic        big_endian;
    logic        lp_valid, lp_we;
    logic [9:0]  lp_port;
    logic [7:0]  lp_wdata, lp_rdata;
    logic        mr_valid, mr_we;
    logic [3:0]  mr_index;
    logic [15:0] mr_wdata, mr_rdata;

    int checks = 0;
    int failures = 0;
    int lp_cnt = 0;
    int mr_cnt = 0;
    logic [9:0]  lp_log_port [4];
    logic [7:0]  lp_log_data [4];
    logic        lp_log_we   [4];
    logic [3:0]  mr_last_idx;
    logic [15:0] mr_last_data;
    logic        mr_last_we;

    always #4 clk = ~clk;

    // downstream models: read values depend on the port / index
    assign lp_rdata = lp_port[7:0] ^ 8'hA5;
    assign mr_rdata = {8'hB4, 4'h0, mr_index};

    regwin_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .qext_en(qext_en), .req(req), .we(we),
        .size(size), .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
        .revision(revision), .big_endian(big_endian),
        .lp_valid(lp_valid), .lp_we(lp_we), .lp_port(lp_port),
        .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .mr_valid(mr_valid), .mr_we(mr_we), .mr_index(mr_index),
        .mr_wdata(mr_wdata), .mr_rdata(mr_rdata)
    );

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (lp_valid) begin
            lp_log_port[lp_cnt % 4] = lp_port;
            lp_log_data[lp_cnt % 4] = lp_wdata;
            lp_log_we[lp_cnt % 4]   = lp_we;
            lp_cnt = lp_cnt + 1;
        end
        if (mr_valid) begin
            mr_last_idx  = mr_index;
            mr_last_data = mr_wdata;
            mr_last_we   = mr_we;
            mr_cnt = mr_cnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int lp_base, mr_base;

    task automatic access(input logic [1:0] sz, input logic [11:0] a, input logic w,
                          input logic [31:0] d, output logic [31:0] rd, output int lat);
        @(posedge clk); #1;
        req = 1'b1; size = sz; addr = a; we = w; wdata = d;
        lp_base = lp_cnt; mr_base = mr_cnt; lat = 0;
        while (1) begin
            @(negedge clk);
            lat = lat + 1;
            if (ready || lat > 8) break;
        end
        rd = rdata;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
    endtask

    // {size[1:0], addr[11:0], exp_rdata[31:0], latency[1:0], lp strobes[1:0], mr strobes}
    localparam int NV = 15;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 12'h400, 32'h0000_0065, 2'd2, 2'd1, 1'b0},
        {2'd0, 12'h41F, 32'h0000_007A, 2'd2, 2'd1, 1'b0},
        {2'd1, 12'h404, 32'h0000_6061, 2'd3, 2'd2, 1'b0},
        {2'd1, 12'h41E, 32'h0000_7A7B, 2'd3, 2'd2, 1'b0},
        {2'd1, 12'h500, 32'h0000_B400, 2'd2, 2'd0, 1'b1},
        {2'd1, 12'h514, 32'h0000_B40A, 2'd2, 2'd0, 1'b1},
        {2'd0, 12'h503, 32'h0000_B401, 2'd2, 2'd0, 1'b1},
        {2'd2, 12'h600, 32'h0000_0008, 2'd2, 2'd0, 1'b0},
        {2'd2, 12'h604, 32'h1E1E_1E1E, 2'd2, 2'd0, 1'b0},
        {2'd1, 12'h600, 32'h0000_0000, 2'd2, 2'd0, 1'b0},
        {2'd2, 12'h602, 32'h0000_0000, 2'd2, 2'd0, 1'b0},
        {2'd2, 12'h000, 32'h0000_0000, 2'd2, 2'd0, 1'b0},
        {2'd0, 12'h420, 32'h0000_0000, 2'd2, 2'd0, 1'b0},
        {2'd1, 12'h516, 32'h0000_0000, 2'd2, 2'd0, 1'b0},
        {2'd2, 12'h608, 32'h0000_0000, 2'd2, 2'd0, 1'b0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks = checks + 1;
        failures = failures + 1;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int lat;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", 32'(ready), 32'h0);
        check("R1 flag in reset", 32'(big_endian), 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 revision enabled", 32'(revision), 32'd2);

        // table walk: reads over all windows and bounds (R2 R4 R5 R6 R7 R9 R11 R12)
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][50:49], VEC[i][48:37], 1'b0, 32'h0, rd, lat);
            check($sformatf("R2/R4/R5/R6/R9/R11 rdata vec%0d", i), rd, VEC[i][36:5]);
            check($sformatf("R12 latency vec%0d", i), 32'(lat), 32'(VEC[i][4:3]));
            check($sformatf("R2/R11 lp strobes vec%0d", i), 32'(lp_cnt - lp_base), 32'(VEC[i][2:1]));
            check($sformatf("R5/R11 mr strobes vec%0d", i), 32'(mr_cnt - mr_base), 32'(VEC[i][0]));
        end

        // R3 split word write: low byte first to addressed port, then high byte
        access(2'd1, 12'h414, 1'b1, 32'h0000_AB12, rd, lat);
        check("R3 strobe count", 32'(lp_cnt - lp_base), 32'd2);
        check("R3 first port", 32'(lp_log_port[lp_base % 4]), 32'h3D4);
        check("R3 first data", 32'(lp_log_data[lp_base % 4]), 32'h12);
        check("R3 second port", 32'(lp_log_port[(lp_base + 1) % 4]), 32'h3D5);
        check("R3 second data", 32'(lp_log_data[(lp_base + 1) % 4]), 32'hAB);
        check("R3 write flag", 32'(lp_log_we[(lp_base + 1) % 4]), 32'h1);
        check("R12 split write latency", 32'(lat), 32'd3);

        // R2 byte write
        access(2'd0, 12'h401, 1'b1, 32'h0000_5577, rd, lat);
        check("R2 byte write count", 32'(lp_cnt - lp_base), 32'd1);
        check("R2 byte write port", 32'(lp_log_port[lp_base % 4]), 32'h3C1);
        check("R2 byte write data", 32'(lp_log_data[lp_base % 4]), 32'h77);

        // R5 mode write with word size carries 16 bits
        access(2'd2, 12'h50A, 1'b1, 32'hFFFF_1234, rd, lat);
        check("R5 mode index", 32'(mr_last_idx), 32'd5);
        check("R5 mode data", 32'(mr_last_data), 32'h1234);
        check("R5 mode we", 32'(mr_last_we), 32'h1);

        // R7 select big-endian
        access(2'd2, 12'h604, 1'b1, 32'hBEBE_BEBE, rd, lat);
        check("R7 flag big", 32'(big_endian), 32'h1);
        access(2'd2, 12'h604, 1'b0, 32'h0, rd, lat);
        check("R7 read big", rd, 32'hBEBE_BEBE);
        // R8 other values ignored
        access(2'd2, 12'h604, 1'b1, 32'h1234_5678, rd, lat);
        access(2'd2, 12'h604, 1'b1, 32'h1E1E_1E1F, rd, lat);
        access(2'd2, 12'h600, 1'b1, 32'h1E1E_1E1E, rd, lat);
        check("R8 flag held", 32'(big_endian), 32'h1);
        access(2'd2, 12'h600, 1'b0, 32'h0, rd, lat);
        check("R8 size reg read-only", rd, 32'h8);
        // R7 back to little
        access(2'd2, 12'h604, 1'b1, 32'h1E1E_1E1E, rd, lat);
        check("R7 flag little", 32'(big_endian), 32'h0);
        // R9 narrow write ignored
        access(2'd1, 12'h604, 1'b1, 32'hBEBE_BEBE, rd, lat);
        check("R9 narrow write ignored", 32'(big_endian), 32'h0);
        // R11 unmapped write has no side effect
        access(2'd2, 12'h7F0, 1'b1, 32'hBEBE_BEBE, rd, lat);
        check("R11 unmapped write no strobe", 32'(lp_cnt - lp_base + mr_cnt - mr_base), 32'd0);
        check("R11 unmapped write flag", 32'(big_endian), 32'h0);

        // R10 bank disabled
        @(posedge clk); #1 qext_en = 1'b0;
        @(negedge clk);
        check("R10 revision disabled", 32'(revision), 32'd1);
        access(2'd2, 12'h600, 1'b0, 32'h0, rd, lat);
        check("R10 disabled read", rd, 32'h0);
        access(2'd2, 12'h604, 1'b1, 32'hBEBE_BEBE, rd, lat);
        check("R10 disabled write", 32'(big_endian), 32'h0);
        @(posedge clk); #1 qext_en = 1'b1;
        access(2'd2, 12'h604, 1'b0, 32'h0, rd, lat);
        check("R10 re-enabled read", rd, 32'h1E1E_1E1E);

        // R1 reset clears a big-endian flag
        access(2'd2, 12'h604, 1'b1, 32'hBEBE_BEBE, rd, lat);
        check("R1 pre-reset big", 32'(big_endian), 32'h1);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clears flag", 32'(big_endian), 32'h0);
        check("R1 reset ready low", 32'(ready), 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule